// File: doc/BRIEF.md
# Protected Page Write Buffer

This block sits behind a two-wire serial slave. It collects the data bytes of one write transaction into a page latch, marks which latch slots actually received a byte, and writes them into a behavioural byte array once the transaction ends cleanly. The slave decodes the bus itself. It hands this block short event pulses: a START, a load of the 16-bit address (given as an array-width address), a strobe for each data byte, and a STOP. The STOP pulse carries a flag that says whether it came right after an acknowledge slot.

All bytes of one transaction stay inside a single row of `2**PAGE_W` bytes. The row is chosen by the address bits above the row offset. Only the offset advances after each byte, so a long burst wraps around and overwrites the start of the same row. A write-control input protects the upper quarter of the array. The block latches that input across the window from START up to and including the address load, and applies it at commit.

A commit starts a self-timed write cycle of `WRITE_CYCLES` clocks. During that cycle `busy` is high and every bus event is ignored. The slave withholds acknowledges while `busy` is high, which lets the master poll for the end of the write. A registered read port returns array bytes and does not look at the write-control input.

Top module: `page_wbuf`

## Requirements
- R1: After a committed transaction, each byte received lands at `{row, offset}`, where row and offset come from the loaded address. Offsets that received no byte keep their old value.
- R2: After each byte only the low `PAGE_W` address bits advance. Offset `2**PAGE_W-1` wraps to offset 0 of the same row. A later byte that reaches an offset already written in the transaction replaces the earlier one.
- R3: A STOP with `stop_after_ack`=1 and at least one latched byte commits. A STOP with `stop_after_ack`=0 discards the latched bytes and starts no write cycle. A STOP with no latched bytes (address-only dummy write) starts no write cycle either.
- R4: If `wc_in` is 1 in any cycle from START through the address-load cycle, the committed transaction leaves unchanged every location whose two top address bits are 2'b11. Locations in the other three quarters are still written.
- R5: A `wc_in` level of 1 that appears only after the address load does not protect anything. With `wc_in` low the whole array is writable.
- R6: `busy` rises in the cycle after a commit and stays high for exactly `WRITE_CYCLES` cycles.
- R7: While `busy` is high, START, address load, data strobes and STOP are ignored. The array does not change and no new write cycle begins.
- R8: A START discards any latched bytes, so a following STOP after an acknowledge slot commits nothing.
- R9: `rd_data` shows the byte at `rd_addr` one clock after `rd_addr` is applied, whatever the level of `wc_in`.
- R10: After reset every array byte reads 8'hFF and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | 1 | One-cycle pulse: START or repeated START seen |
| addr_load | input | 1 | One-cycle pulse: address bytes complete, `addr_in` valid |
| addr_in | input | ADDR_W | Byte address loaded into the write pointer |
| data_stb | input | 1 | One-cycle pulse: a data byte has been received |
| data_in | input | 8 | Data byte that goes with `data_stb` |
| stop_evt | input | 1 | One-cycle pulse: STOP seen |
| stop_after_ack | input | 1 | STOP followed an acknowledge slot (byte boundary) |
| wc_in | input | 1 | Write-control level; 1 protects the top quarter |
| rd_addr | input | ADDR_W | Read address |
| busy | output | 1 | Self-timed write cycle in progress |
| rd_data | output | 8 | Registered read data |

## Verification
The bound checker watches several rules on every cycle. It checks the length of each `busy` pulse against `WRITE_CYCLES` with a counter. It checks that a commit is followed by `busy`, and that a STOP not after an acknowledge slot, or a START, leaves the latch empty and no cycle running. It also checks that `wc_in` seen in the header window sticks in the protection latch.

Other behaviours need the bench's scenarios and read-back, because they only show up in array contents after a commit. These are where bytes land, the row wrap and overwrite order, the skipping of protected quarter locations, and that events sent during `busy` leave the array untouched.

// File: rtl/page_wbuf_pkg.sv
package page_wbuf_pkg;

  // Advance an address inside its row: only the low page_w bits count.
  function automatic logic [31:0] row_advance(input logic [31:0] a, input int unsigned page_w);
    logic [31:0] m;
    m = (32'd1 << page_w) - 32'd1;
    return (a & ~m) | ((a + 32'd1) & m);
  endfunction

  // True when the two top bits of an addr_w-bit address are both set.
  function automatic logic top_quarter(input logic [31:0] a, input int unsigned addr_w);
    return ((a >> (addr_w - 2)) & 32'd3) == 32'd3;
  endfunction

endpackage

// File: rtl/page_wbuf_wp_sample.sv
module page_wbuf_wp_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic hdr_end_i,
  input  logic wc_i,
  output logic hdr_open_o,
  output logic wc_lat_o
);
  logic open_q;
  logic lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      lat_q  <= 1'b0;
    end else if (start_i) begin
      open_q <= 1'b1;
      lat_q  <= wc_i;
    end else if (open_q) begin
      lat_q <= lat_q | wc_i;
      if (hdr_end_i) open_q <= 1'b0;
    end
  end

  assign hdr_open_o = open_q;
  assign wc_lat_o   = lat_q;
endmodule

// File: rtl/page_wbuf_latch.sv
module page_wbuf_latch
  import page_wbuf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        strobe_i,
  input  logic [7:0]                  data_i,
  input  logic                        clear_i,
  output logic [ADDR_W-PAGE_W-1:0]    row_o,
  output logic [(1<<PAGE_W)-1:0][7:0] data_o,
  output logic [(1<<PAGE_W)-1:0]      valid_o
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [ADDR_W-1:0] ptr_q;
  logic [PAGE_W-1:0] slot;

  assign slot  = ptr_q[PAGE_W-1:0];
  assign row_o = ptr_q[ADDR_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (load_i)   ptr_q <= addr_i;
    else if (strobe_i) ptr_q <= ADDR_W'(row_advance(32'(ptr_q), PAGE_W));
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic       v_q;
    logic [7:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 8'h00;
      end else if (clear_i) begin
        v_q <= 1'b0;
      end else if (strobe_i && slot == PAGE_W'(g)) begin
        v_q <= 1'b1;
        d_q <= data_i;
      end
    end
    assign valid_o[g] = v_q;
    assign data_o[g]  = d_q;
  end
endmodule

// File: rtl/page_wbuf_timer.sv
module page_wbuf_timer #(
  parameter int WRITE_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (fire_i)         cnt_q <= CNT_W'(WRITE_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/page_wbuf_array.sv
module page_wbuf_array
  import page_wbuf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]    row_i,
  input  logic [(1<<PAGE_W)-1:0][7:0] data_i,
  input  logic [(1<<PAGE_W)-1:0]      valid_i,
  input  logic                        protect_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [7:0]                  rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      rd_data_o <= 8'hFF;
    end else begin
      if (commit_i) begin
        for (int j = 0; j < SLOTS; j++) begin
          if (valid_i[j] &&
              !(protect_i && top_quarter(32'({row_i, PAGE_W'(j)}), ADDR_W)))
            mem[{row_i, PAGE_W'(j)}] <= data_i[j];
        end
      end
      rd_data_o <= mem[rd_addr_i];
    end
  end
endmodule

// File: rtl/page_wbuf.sv
module page_wbuf #(
  parameter int ADDR_W       = 9,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_stb,
  input  logic [7:0]        data_in,
  input  logic              stop_evt,
  input  logic              stop_after_ack,
  input  logic              wc_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic [7:0]        rd_data
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;

  // Bus events, gated off while the write cycle runs.
  logic start_g, load_g, stb_g, stop_g;
  logic commit_fire;
  logic valid_any;
  logic hdr_open, wc_lat;

  logic [ROW_W-1:0]           row;
  logic [SLOTS-1:0][7:0]      page_data;
  logic [SLOTS-1:0]           page_valid;

  assign start_g     = start_evt & ~busy;
  assign load_g      = addr_load & ~busy;
  assign stb_g       = data_stb  & ~busy;
  assign stop_g      = stop_evt  & ~busy;
  assign valid_any   = |page_valid;
  assign commit_fire = stop_g & stop_after_ack & valid_any;

  page_wbuf_wp_sample u_wp (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_g),
    .hdr_end_i  (load_g),
    .wc_i       (wc_in),
    .hdr_open_o (hdr_open),
    .wc_lat_o   (wc_lat)
  );

  page_wbuf_latch #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_g),
    .addr_i   (addr_in),
    .strobe_i (stb_g),
    .data_i   (data_in),
    .clear_i  (start_g | stop_g),
    .row_o    (row),
    .data_o   (page_data),
    .valid_o  (page_valid)
  );

  page_wbuf_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (commit_fire),
    .busy_o (busy)
  );

  page_wbuf_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit_fire),
    .row_i     (row),
    .data_i    (page_data),
    .valid_i   (page_valid),
    .protect_i (wc_lat),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/page_wbuf_chk.sv
module page_wbuf_chk #(
  parameter int WRITE_CYCLES = 20
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic commit_fire,
  input logic start_g,
  input logic stb_g,
  input logic stop_g,
  input logic stop_after_ack,
  input logic hdr_open,
  input logic wc_in,
  input logic wc_lat,
  input logic valid_any
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  assert_busy_follows_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> busy);

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == WRITE_CYCLES);

  assert_busy_not_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_len < WRITE_CYCLES);

  assert_bad_stop_discards_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_g && !stop_after_ack) |=> (!busy && !valid_any));

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_g |=> !valid_any);

  assert_wc_window_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_open && !start_g && wc_in) |=> wc_lat);

  assert_strobe_latches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_g && !start_g && !stop_g) |=> valid_any);
endmodule

bind page_wbuf page_wbuf_chk #(.WRITE_CYCLES(WRITE_CYCLES)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .commit_fire    (commit_fire),
  .start_g        (start_g),
  .stb_g          (stb_g),
  .stop_g         (stop_g),
  .stop_after_ack (stop_after_ack),
  .hdr_open       (hdr_open),
  .wc_in          (wc_in),
  .wc_lat         (wc_lat),
  .valid_any      (valid_any)
);

// File: tb/page_wbuf_tb_top.sv
module page_wbuf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 9;
  localparam int PAGE_W = 5;
  localparam int WCYC   = 20;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SLOTS  = 1 << PAGE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_evt = 0, addr_load = 0, data_stb = 0, stop_evt = 0, stop_after_ack = 0, wc_in = 0;
  logic [ADDR_W-1:0] addr_in = '0, rd_addr = '0;
  logic [7:0] data_in = '0;
  logic busy;
  logic [7:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_wbuf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .addr_load(addr_load), .addr_in(addr_in),
    .data_stb(data_stb), .data_in(data_in), .stop_evt(stop_evt), .stop_after_ack(stop_after_ack),
    .wc_in(wc_in), .rd_addr(rd_addr), .busy(busy), .rd_data(rd_data));

  int checks = 0;
  int errors = 0;

  // Reference model state
  int m_mem [DEPTH];
  int m_dat [SLOTS];
  bit m_val [SLOTS];
  int m_ptr = 0;
  bit m_wc = 0, m_open = 0;
  bit ign = 0;

  function automatic bit is_prot_loc(int a);
    return a >= (DEPTH * 3) / 4;
  endfunction

  function automatic int next_in_row(int a);
    return (a / SLOTS) * SLOTS + ((a % SLOTS) + 1) % SLOTS;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_latch();
    for (int i = 0; i < SLOTS; i++) m_val[i] = 0;
  endtask

  task automatic ev_start(input bit wc);
    @(negedge clk); start_evt = 1; wc_in = wc;
    if (!ign) begin clr_latch(); m_open = 1; m_wc = wc; end
    @(negedge clk); start_evt = 0;
  endtask

  task automatic ev_load(input int a, input bit wc);
    @(negedge clk); addr_load = 1; addr_in = ADDR_W'(a); wc_in = wc;
    if (!ign) begin m_ptr = a; if (m_open) begin m_wc = m_wc | wc; m_open = 0; end end
    @(negedge clk); addr_load = 0;
  endtask

  task automatic ev_byte(input int d);
    @(negedge clk); data_stb = 1; data_in = 8'(d);
    if (!ign) begin m_dat[m_ptr % SLOTS] = d; m_val[m_ptr % SLOTS] = 1; m_ptr = next_in_row(m_ptr); end
    @(negedge clk); data_stb = 0;
  endtask

  // Returns with the model expecting busy (1) or not (0).
  task automatic ev_stop(input bit ack, output bit exp_busy);
    bit any;
    any = 0;
    for (int i = 0; i < SLOTS; i++) any |= m_val[i];
    exp_busy = 0;
    @(negedge clk); stop_evt = 1; stop_after_ack = ack;
    if (!ign) begin
      if (ack && any) begin
        exp_busy = 1;
        for (int i = 0; i < SLOTS; i++)
          if (m_val[i]) begin
            int a;
            a = (m_ptr / SLOTS) * SLOTS + i;
            if (!(m_wc && is_prot_loc(a))) m_mem[a] = m_dat[i];
          end
      end
      clr_latch();
    end
    @(negedge clk); stop_evt = 0; stop_after_ack = 0;
  endtask

  task automatic stop_and_wait(input bit ack);
    bit eb;
    int n;
    ev_stop(ack, eb);
    chk(eb ? "R6 busy after commit" : "R3 no write cycle", int'(busy), int'(eb));
    n = 0;
    while (busy && n < 4 * WCYC) begin n++; @(negedge clk); end
    if (eb) chk("R6 busy length", n, WCYC);
  endtask

  task automatic rd_chk(input string req, input int a);
    @(negedge clk); rd_addr = ADDR_W'(a);
    @(negedge clk);
    chk(req, int'(rd_data), m_mem[a]);
  endtask

  task automatic row_chk(input string req, input int row);
    for (int i = 0; i < SLOTS; i++) rd_chk(req, row * SLOTS + i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;
    clr_latch();
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    chk("R10 busy after reset", int'(busy), 0);
    rd_chk("R10 erased", 0);
    rd_chk("R10 erased", DEPTH - 1);
    rd_chk("R10 erased", 200);

    // R1 single byte, neighbours untouched
    ev_start(0); ev_load(19, 0); ev_byte(8'h5A); stop_and_wait(1);
    rd_chk("R1 byte written", 19);
    rd_chk("R1 neighbour kept", 18);
    rd_chk("R1 neighbour kept", 20);

    // R2 wrap across row end
    ev_start(0); ev_load(2 * SLOTS + 30, 0);
    for (int i = 0; i < 4; i++) ev_byte(8'h10 + i);
    stop_and_wait(1);
    row_chk("R2 wrap in row", 2);
    rd_chk("R2 next row untouched", 3 * SLOTS);
    // R2 overwrite by long burst
    ev_start(0); ev_load(4 * SLOTS, 0);
    for (int i = 0; i < SLOTS + 2; i++) ev_byte(i + 1);
    stop_and_wait(1);
    rd_chk("R2 overwrite slot0", 4 * SLOTS);
    rd_chk("R2 overwrite slot1", 4 * SLOTS + 1);
    rd_chk("R2 plain slot", 4 * SLOTS + 5);

    // R3 stop off boundary discards, dummy write commits nothing
    ev_start(0); ev_load(5 * SLOTS, 0); ev_byte(8'h77); ev_byte(8'h78);
    stop_and_wait(0);
    row_chk("R3 discarded", 5);
    ev_start(0); ev_load(5 * SLOTS + 3, 0); stop_and_wait(1);
    // discarded bytes must not reappear on a later clean stop
    stop_and_wait(1);
    rd_chk("R3 stale bytes gone", 5 * SLOTS);

    // R4 wc high only at START
    ev_start(1); ev_load(DEPTH - SLOTS, 0); ev_byte(8'h11); ev_byte(8'h12);
    stop_and_wait(1);
    rd_chk("R4 protected at start", DEPTH - SLOTS);
    rd_chk("R4 protected at start", DEPTH - SLOTS + 1);
    // R4 wc high only at address load
    ev_start(0); ev_load(DEPTH - 2 * SLOTS + 4, 1); wc_in = 0; ev_byte(8'h21);
    stop_and_wait(1);
    rd_chk("R4 protected at load", DEPTH - 2 * SLOTS + 4);
    // R4 lower quarter still written with wc high
    ev_start(1); ev_load(DEPTH / 2 + 7, 1); ev_byte(8'h33);
    stop_and_wait(1);
    rd_chk("R4 other quarter written", DEPTH / 2 + 7);
    // R5 wc high only during data
    ev_start(0); ev_load(DEPTH - SLOTS + 9, 0);
    @(negedge clk); wc_in = 1;
    ev_byte(8'h44);
    stop_and_wait(1);
    wc_in = 0;
    rd_chk("R5 late wc no protect", DEPTH - SLOTS + 9);

    // R7 events during busy ignored
    begin
      bit eb;
      ev_start(0); ev_load(6 * SLOTS, 0); ev_byte(8'h66); ev_stop(1, eb);
      chk("R7 busy began", int'(busy), 1);
      ign = 1;
      ev_start(0); ev_load(7 * SLOTS, 0); ev_byte(8'h99); ev_byte(8'h98);
      ev_stop(1, eb);
      ign = 0;
      while (busy) @(negedge clk);
      @(negedge clk);
      chk("R7 no second cycle", int'(busy), 0);
      row_chk("R7 ignored row", 7);
      rd_chk("R7 real write", 6 * SLOTS);
    end

    // R8 start clears latch
    ev_start(0); ev_load(8 * SLOTS, 0); ev_byte(8'hAB); ev_start(0);
    stop_and_wait(1);
    rd_chk("R8 cleared by start", 8 * SLOTS);

    // R9 reads independent of wc
    wc_in = 1;
    rd_chk("R9 read wc high", DEPTH - SLOTS + 9);
    rd_chk("R9 read wc high", 19);
    wc_in = 0;

    // Random transactions
    for (int t = 0; t < 40; t++) begin
      int a, n;
      bit w1, w2, ack;
      a   = int'($urandom_range(DEPTH - 1));
      n   = int'($urandom_range(SLOTS + 6, 1));
      w1  = ($urandom_range(3) == 0);
      w2  = ($urandom_range(3) == 0);
      ack = ($urandom_range(4) != 0);
      ev_start(w1); ev_load(a, w2);
      wc_in = 1'($urandom_range(1));
      for (int i = 0; i < n; i++) ev_byte(int'($urandom_range(255)));
      stop_and_wait(ack);
      wc_in = 0;
      row_chk(is_prot_loc(a) ? "R4 random row" : "R1 random row", a / SLOTS);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule